// File: doc/BRIEF.md
# Carrier Detect Timer with Hysteresis

This block turns a per-sample in-band energy flag from an FSK demodulator into a carrier-detect status. The status (active low) goes active only after energy has been seen for a qualifying run of consecutive clock samples. Once active, it is released only after energy has been missing for a longer run of consecutive samples. Short breaks in the carrier are therefore bridged and do not make the status toggle. Any in-band energy counts, voice included, because the block cannot tell the two apart.

The same status also drives a gate for the serial data path. Received data may leave its idle-high level only while the gate is open, and the gate is open exactly while carrier detect is active. A power-down input forces the status inactive and clears all timing state on the next clock edge. Both delays are parameters given in clock cycles. At a 3.58 MHz clock, about 8 ms to assert and 11 ms to release would be typical values.

Top module: `carrier_detect_timer`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), cd_n is 1 and data_gate is 0.
- R2: From the inactive state, cd_n goes to 0 in the cycle after the clock edge at which energy_in has been sampled 1 for ASSERT_CYCLES consecutive edges with pwr_down 0.
- R3: An edge with energy_in 0 before the qualifying run completes restarts the qualification, so a fresh run of ASSERT_CYCLES consecutive energy samples is needed.
- R4: While active, cd_n stays 0 through any run of energy_in 0 samples that is shorter than HOLD_CYCLES.
- R5: While active, cd_n returns to 1 in the cycle after the edge at which energy_in has been sampled 0 for HOLD_CYCLES consecutive edges.
- R6: An edge with energy_in 1 during a release run clears that run, so HOLD_CYCLES fresh consecutive absent samples are needed before release.
- R7: pwr_down sampled 1 at an edge makes cd_n 1 and data_gate 0 after that edge, and clears both run counts.
- R8: data_gate is 1 exactly when cd_n is 0.
- R9: energy_in has no effect while pwr_down is 1. After power-down ends, a full qualifying run is needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwr_down | input | 1 | Power-down; forces release and clears timers |
| energy_in | input | 1 | In-band energy present for this sample |
| cd_n | output | 1 | Carrier detect, active low |
| data_gate | output | 1 | High when the data output may leave idle-high |

## Verification
The bench drives long steady energy, runs that end one sample short of each threshold, and dropout trains that are shorter or longer than the hold window. Short runs separate a counter that restarts on a gap from one that only pauses. Dropouts ended by returning energy separate a hold counter that clears from one that accumulates. Random bursty traffic mixed with power-down pulses checks that power-down clears timing state. Each output is compared every cycle against a run-length model.

// File: rtl/cdt_pkg.sv
// Package: shared state type and width helper for the carrier detect timer.
package cdt_pkg;
    // Carrier status held by the state controller.
    typedef enum logic {
        CDT_IDLE   = 1'b0,
        CDT_LOCKED = 1'b1
    } cdt_state_t;

    // Bits needed to hold a count from 0 to limit.
    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction
endpackage

// File: rtl/cdt_run_counter.sv
// Module: cdt_run_counter
// Counts consecutive cycles with count_en high. It restarts at zero on any
// cycle with count_en low or clear high. hit pulses in the cycle in which the
// LIMIT-th consecutive enabled sample is taken; the count then returns to zero.
// Assumes LIMIT >= 1.
module cdt_run_counter #(
    parameter int unsigned LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic count_en,
    output logic hit
);
    localparam int unsigned W = cdt_pkg::cnt_width(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] run_q;

    // Terminal detect: this enabled sample completes the run.
    always_comb begin
        hit = count_en && !clear && (run_q == LAST);
    end

    // Run-length register: count, restart on gap, clear or terminal.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !count_en || hit) begin
            run_q <= '0;
        end else begin
            run_q <= run_q + W'(1);
        end
    end
endmodule

// File: rtl/cdt_state_ctrl.sv
// Module: cdt_state_ctrl
// Holds the carrier status. Goes locked on a qualify hit and idle on a hold
// hit. Power-down or reset forces idle. Assumes the hit inputs come from
// counters that are enabled only in the matching state.
module cdt_state_ctrl
    import cdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_down,
    input  logic       qual_hit,
    input  logic       hold_hit,
    output cdt_state_t state
);
    cdt_state_t state_d;

    // Next-state selection.
    always_comb begin
        state_d = state;
        unique case (state)
            CDT_IDLE:   if (qual_hit) state_d = CDT_LOCKED;
            CDT_LOCKED: if (hold_hit) state_d = CDT_IDLE;
            default:    state_d = CDT_IDLE;
        endcase
    end

    // State register with synchronous reset and power-down.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down) begin
            state <= CDT_IDLE;
        end else begin
            state <= state_d;
        end
    end
endmodule

// File: rtl/carrier_detect_timer.sv
// Module: carrier_detect_timer (top)
// Qualifies in-band energy into an active-low carrier-detect with asymmetric
// assert/release delays, and gates the data path on it. Assumes
// HOLD_CYCLES > ASSERT_CYCLES >= 1, and energy_in synchronous to clk.
module carrier_detect_timer
    import cdt_pkg::*;
#(
    parameter int unsigned ASSERT_CYCLES = 28636,
    parameter int unsigned HOLD_CYCLES   = 39375
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down,
    input  logic energy_in,
    output logic cd_n,
    output logic data_gate
);
    cdt_state_t state;
    logic       locked;
    logic       qual_hit;
    logic       hold_hit;
    logic       qual_clear;
    logic       hold_clear;

    // Counter clears: each counter runs only in its own state.
    always_comb begin
        locked     = (state == CDT_LOCKED);
        qual_clear = pwr_down || locked;
        hold_clear = pwr_down || !locked;
    end

    cdt_run_counter #(.LIMIT(ASSERT_CYCLES)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (qual_clear),
        .count_en (energy_in),
        .hit      (qual_hit)
    );

    cdt_run_counter #(.LIMIT(HOLD_CYCLES)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (hold_clear),
        .count_en (!energy_in),
        .hit      (hold_hit)
    );

    cdt_state_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_down (pwr_down),
        .qual_hit (qual_hit),
        .hold_hit (hold_hit),
        .state    (state)
    );

    // Output mapping: active-low status and data gate.
    always_comb begin
        cd_n      = !locked;
        data_gate = locked;
    end
endmodule

// File: rtl/carrier_detect_timer_chk.sv
// Module: carrier_detect_timer_chk
// Port-level checker with its own run-length counters, bound into the top.
module carrier_detect_timer_chk #(
    parameter int unsigned ASSERT_CYCLES = 8,
    parameter int unsigned HOLD_CYCLES   = 11
) (
    input logic clk,
    input logic rst_n,
    input logic pwr_down,
    input logic energy_in,
    input logic cd_n,
    input logic data_gate
);
    int unsigned on_run;
    int unsigned off_run;

    // Consecutive energy-present and energy-absent runs, saturated.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down) begin
            on_run  <= 0;
            off_run <= 0;
        end else if (energy_in) begin
            on_run  <= (on_run < ASSERT_CYCLES) ? on_run + 1 : on_run;
            off_run <= 0;
        end else begin
            off_run <= (off_run < HOLD_CYCLES) ? off_run + 1 : off_run;
            on_run  <= 0;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (cd_n && !data_gate));

    assert_qualified_assert_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cd_n) |-> (on_run >= ASSERT_CYCLES));

    assert_hold_bridge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cd_n) && !$past(pwr_down)) |-> (off_run >= HOLD_CYCLES));

    assert_pwr_down_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> cd_n);

    assert_gate_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        data_gate == !cd_n);
endmodule

bind carrier_detect_timer carrier_detect_timer_chk #(
    .ASSERT_CYCLES (ASSERT_CYCLES),
    .HOLD_CYCLES   (HOLD_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_down  (pwr_down),
    .energy_in (energy_in),
    .cd_n      (cd_n),
    .data_gate (data_gate)
);

// File: tb/carrier_detect_timer_bench.sv
module carrier_detect_timer_bench;
    localparam int unsigned A = 6;
    localparam int unsigned H = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_down = 1'b0;
    logic energy_in = 1'b0;
    logic cd_n;
    logic data_gate;

    int checks = 0;
    int errors = 0;
    int m_lock = 0;
    int m_on = 0;
    int m_off = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    carrier_detect_timer #(.ASSERT_CYCLES(A), .HOLD_CYCLES(H)) u_carrier_detect_timer (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .energy_in(energy_in),
        .cd_n(cd_n), .data_gate(data_gate)
    );

    // Reference: run-length model written from the requirements.
    function automatic void model_step(input bit rst, input bit pd, input bit e);
        if (rst || pd) begin
            m_lock = 0; m_on = 0; m_off = 0;
        end else if (m_lock == 0) begin
            if (e) begin
                m_on++;
                if (m_on == A) begin m_lock = 1; m_on = 0; end
            end else m_on = 0;
        end else begin
            if (!e) begin
                m_off++;
                if (m_off == H) begin m_lock = 0; m_off = 0; end
            end else m_off = 0;
        end
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, model at posedge, compare at next negedge.
    task automatic cyc(input bit rst, input bit pd, input bit e, input string req);
        rst_n = !rst; pwr_down = pd; energy_in = e;
        @(posedge clk);
        model_step(rst, pd, e);
        @(negedge clk);
        check(req, cd_n, (m_lock == 0));
        check("R8", data_gate, (m_lock == 1));
    endtask

    task automatic run(input int n, input bit pd, input bit e, input string req);
        for (int i = 0; i < n; i++) cyc(1'b0, pd, e, req);
    endtask

    initial begin
        int seed;
        seed = 32'h5eed_c0de;
        void'($urandom(seed));
        @(negedge clk);
        cyc(1'b1, 1'b0, 1'b1, "R1");
        cyc(1'b1, 1'b0, 1'b0, "R1");
        // R2: exact threshold run.
        run(A - 1, 1'b0, 1'b1, "R2");
        check("R2 not yet", cd_n, 1'b1);
        run(1, 1'b0, 1'b1, "R2");
        check("R2 asserted", cd_n, 1'b0);
        // R4: dropout one short of hold.
        run(H - 1, 1'b0, 1'b0, "R4");
        check("R4 bridged", cd_n, 1'b0);
        // R6: energy returns, then H-1 absent must still hold.
        run(1, 1'b0, 1'b1, "R6");
        run(H - 1, 1'b0, 1'b0, "R6");
        check("R6 hold cleared", cd_n, 1'b0);
        // R5: one more absent sample completes a full run.
        run(1, 1'b0, 1'b0, "R5");
        check("R5 released", cd_n, 1'b1);
        // R3: short run, gap, short run.
        run(A - 1, 1'b0, 1'b1, "R3");
        run(1, 1'b0, 1'b0, "R3");
        run(A - 1, 1'b0, 1'b1, "R3");
        check("R3 restarted", cd_n, 1'b1);
        run(1, 1'b0, 1'b1, "R3");
        check("R3 full run", cd_n, 1'b0);
        // R7: power-down releases.
        run(1, 1'b1, 1'b1, "R7");
        check("R7 released", cd_n, 1'b1);
        check("R7 gate", data_gate, 1'b0);
        // R9: energy during power-down ignored; partial run then needs full run.
        run(A + 3, 1'b1, 1'b1, "R9");
        check("R9 ignored", cd_n, 1'b1);
        run(A - 1, 1'b0, 1'b1, "R9");
        check("R9 fresh run", cd_n, 1'b1);
        run(1, 1'b0, 1'b1, "R9");
        // Random bursty traffic with rare power-down.
        for (int k = 0; k < 400; k++) begin
            int len;
            bit e;
            bit pd;
            len = 1 + ($urandom % (H + 3));
            e = $urandom % 2;
            pd = (($urandom % 16) == 0);
            run(len, pd, e, pd ? "R7" : (e ? "R2" : "R5"));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule